// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst command into the column address sequence an SDRAM device walks through for a read or write burst. A command strobe captures a start column, a burst length code and an ordering bit. From the next clock on, the block drives one column address per cycle together with a valid flag, until the burst is complete.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns whose size equals the burst length. The address either counts upward and wraps inside that group, or follows an XOR (interleaved) order. A full-page burst counts through the whole row and wraps at the top. It stops only when a terminate input ends it or a new command replaces it.

Codes that do not name a supported burst raise a one-cycle error flag instead of starting a burst. Bank and row handling, command timing and the data path sit outside this block.

Top module: `sdram_col_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, valid_o, done_o and err_o are 0.
- R2: Burst length code encoding on bl_code_i: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. When cmd_i is sampled high with a legal code, the next cycle has valid_o = 1 and col_o equal to the sampled start_col_i.
- R3: With btype_i = 0 (sequential) and a fixed length L, beat k has col_o = (start with its low log2(L) bits cleared) + ((start mod L + k) mod L).
- R4: With btype_i = 1 (interleaved) and a fixed length L, beat k has col_o = start XOR k.
- R5: Every beat of a fixed burst of length L keeps the column bits above bit log2(L)-1 equal to those of the start column.
- R6: A fixed burst of length L gives exactly L consecutive valid cycles. The cycle after the last beat has done_o = 1 for one cycle.
- R7: A full-page burst (code 7, sequential) gives col_o = (start + k) mod 2^COL_W on beat k. It keeps running with no done_o, wrapping from the top column to 0.
- R8: term_i sampled high during an active burst, with cmd_i low, makes valid_o 0 from the next cycle and raises no done_o. term_i while idle has no effect.
- R9: Codes 4, 5 and 6, and code 7 with btype_i = 1, are illegal. Such a command gives err_o = 1 for one cycle, issues no beat and ends any active burst.
- R10: cmd_i sampled high during an active burst abandons it, and the next cycle carries the first beat of the new burst. cmd_i has priority over term_i.
- R11: At most one of valid_o, done_o and err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 1 | Burst command strobe |
| bl_code_i | input | 3 | Burst length code |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| start_col_i | input | COL_W | Start column address |
| term_i | input | 1 | Burst terminate |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | High for one cycle per beat |
| done_o | output | 1 | One-cycle pulse after the last beat of a fixed burst |
| err_o | output | 1 | One-cycle pulse for an illegal command |

## Verification
The bench builds the block with the default COL_W of 9. This makes the full-page wrap from column 511 to 0 reachable within a dozen beats from a start near the top of the row. Every burst length and both orderings are reachable at every alignment of the start column inside a 512-column row. Starts are chosen near the top of the row and at odd offsets inside each group, so wrapping inside a group and at the row edge is exercised.

// File: rtl/col_gen_pkg.sv
package col_gen_pkg;
    localparam int unsigned CODE_W = 3;
    localparam logic [CODE_W-1:0] BLC_ONE   = 3'd0;
    localparam logic [CODE_W-1:0] BLC_TWO   = 3'd1;
    localparam logic [CODE_W-1:0] BLC_FOUR  = 3'd2;
    localparam logic [CODE_W-1:0] BLC_EIGHT = 3'd3;
    localparam logic [CODE_W-1:0] BLC_PAGE  = 3'd7;
    localparam logic ORDER_SEQ = 1'b0;
    localparam logic ORDER_XOR = 1'b1;
endpackage

// File: rtl/bl_decode.sv
module bl_decode
    import col_gen_pkg::*;
#(
    parameter int unsigned COL_W = 9,
    localparam int unsigned LG_W = $clog2(COL_W + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              order_i,
    output logic              legal_o,
    output logic              page_o,
    output logic [LG_W-1:0]   lg_o
);
    always_comb begin
        legal_o = 1'b1;
        page_o  = 1'b0;
        lg_o    = '0;
        unique case (code_i)
            BLC_ONE:   lg_o = LG_W'(0);
            BLC_TWO:   lg_o = LG_W'(1);
            BLC_FOUR:  lg_o = LG_W'(2);
            BLC_EIGHT: lg_o = LG_W'(3);
            BLC_PAGE: begin
                lg_o    = LG_W'(COL_W);
                page_o  = 1'b1;
                legal_o = (order_i == ORDER_SEQ);
            end
            default:   legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/col_order_calc.sv
module col_order_calc
    import col_gen_pkg::*;
#(
    parameter int unsigned COL_W = 9,
    localparam int unsigned LG_W = $clog2(COL_W + 1)
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [LG_W-1:0]  lg_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    always_comb begin
        low_mask = (COL_W'(1) << lg_i) - COL_W'(1);
        seq_col  = (start_i & ~low_mask) | ((start_i + beat_i) & low_mask);
        xor_col  = start_i ^ (beat_i & low_mask);
        col_o    = (order_i == ORDER_XOR) ? xor_col : seq_col;
    end
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
    import col_gen_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic [2:0]       bl_code_i,
    input  logic             btype_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int unsigned LG_W = $clog2(COL_W + 1);

    typedef struct packed {
        logic             active;
        logic             page;
        logic [LG_W-1:0]  lg;
        logic             order;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] col;
        logic             valid;
        logic             done;
        logic             err;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic             dec_legal;
    logic             dec_page;
    logic [LG_W-1:0]  dec_lg;
    logic [COL_W-1:0] next_col;
    logic [COL_W-1:0] fixed_len;

    bl_decode #(.COL_W(COL_W)) i_decode (
        .code_i  (bl_code_i),
        .order_i (btype_i),
        .legal_o (dec_legal),
        .page_o  (dec_page),
        .lg_o    (dec_lg)
    );

    col_order_calc #(.COL_W(COL_W)) i_calc (
        .start_i (st_q.start),
        .beat_i  (st_q.beat),
        .lg_i    (st_q.lg),
        .order_i (st_q.order),
        .col_o   (next_col)
    );

    always_comb begin
        fixed_len  = COL_W'(1) << st_q.lg;
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.done  = 1'b0;
        st_d.err   = 1'b0;
        if (cmd_i) begin
            if (!dec_legal) begin
                st_d.err    = 1'b1;
                st_d.active = 1'b0;
            end else begin
                st_d.active = 1'b1;
                st_d.page   = dec_page;
                st_d.lg     = dec_lg;
                st_d.order  = btype_i;
                st_d.start  = start_col_i;
                st_d.col    = start_col_i;
                st_d.beat   = COL_W'(1);
                st_d.valid  = 1'b1;
            end
        end else if (st_q.active) begin
            if (term_i) begin
                st_d.active = 1'b0;
            end else if (!st_q.page && st_q.beat == fixed_len) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.col   = next_col;
                st_d.valid = 1'b1;
                st_d.beat  = st_q.beat + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.valid;
    assign done_o  = st_q.done;
    assign err_o   = st_q.err;

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i && dec_legal) |=> (valid_o && col_o == $past(start_col_i)));

    assert_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (((col_o ^ st_q.start) >> st_q.lg) == '0));

    assert_done_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_o));

    assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && term_i && !cmd_i) |=> (!valid_o && !done_o));

    assert_illegal_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i && !dec_legal) |=> (err_o && !valid_o));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, done_o, err_o}));
endmodule

// File: tb/test_sdram_col_gen.sv
module test_sdram_col_gen;
    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_i = 1'b0;
    logic [2:0]       bl_code_i = '0;
    logic             btype_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, done_o, err_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string focus = "";

    // reference model state
    bit    m_act = 0;
    int    m_start = 0, m_len = 0, m_k = 0;
    bit    m_itl = 0;
    bit    e_valid = 0, e_done = 0, e_err = 0;
    int    e_col = 0;
    string e_tag = "R1";

    sdram_col_gen #(.COL_W(COL_W)) i_sdram_col_gen (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bl_code_i(bl_code_i),
        .btype_i(btype_i), .start_col_i(start_col_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .done_o(done_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    function automatic int ref_col(int s, int k, int len, bit itl);
        int base;
        if (len == 0) return (s + k) % NCOL;
        if (itl) return s ^ k;
        base = s - (s % len);
        return base + ((s % len + k) % len);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (!rst_n) begin
            m_act = 0; e_valid = 0; e_done = 0; e_err = 0; e_tag = "R1";
        end else begin
            e_valid = 0; e_done = 0; e_err = 0;
            if (cmd_i) begin
                bit legal;
                legal = (bl_code_i <= 3) || (bl_code_i == 7 && !btype_i);
                if (!legal) begin
                    e_err = 1; m_act = 0; e_tag = "R9";
                end else begin
                    m_act = 1; m_start = int'(start_col_i); m_itl = btype_i;
                    m_len = (bl_code_i == 7) ? 0 : (1 << bl_code_i);
                    e_valid = 1; e_col = m_start; m_k = 1; e_tag = "R2";
                end
            end else if (m_act) begin
                if (term_i) begin
                    m_act = 0; e_tag = "R8";
                end else if (m_len != 0 && m_k == m_len) begin
                    m_act = 0; e_done = 1; e_tag = "R6";
                end else begin
                    e_col = ref_col(m_start, m_k, m_len, m_itl);
                    e_valid = 1;
                    m_k = (m_k + 1) % NCOL;
                    e_tag = (m_len == 0) ? "R7" : (m_itl ? "R4" : "R3");
                end
            end else begin
                e_tag = "R8";
            end
        end
    end

    always @(negedge clk) begin
        string t;
        t = (focus != "") ? focus : e_tag;
        if (cyc > 0) begin
            check(valid_o == e_valid, t, "valid_o", valid_o, e_valid);
            check(done_o == e_done, (e_done || done_o) ? "R6" : t, "done_o", done_o, e_done);
            check(err_o == e_err, (e_err || err_o) ? "R9" : t, "err_o", err_o, e_err);
            if (e_valid)
                check(int'(col_o) == e_col, t, "col_o", col_o, e_col);
            if (e_valid && m_len != 0)
                check((int'(col_o) / m_len) == (m_start / m_len), "R5", "block", col_o, m_start);
            check($countones({valid_o, done_o, err_o}) <= 1, "R11", "exclusive", valid_o + done_o + err_o, 1);
        end
    end

    task automatic issue(int code, bit itl, int s);
        @(negedge clk);
        cmd_i = 1; bl_code_i = 3'(code); btype_i = itl; start_col_i = COL_W'(s);
        @(negedge clk);
        cmd_i = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_term();
        @(negedge clk);
        term_i = 1;
        @(negedge clk);
        term_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!valid_o && !done_o && !err_o, "R1", "reset outputs", valid_o + done_o + err_o, 0);
        rst_n = 1;
        @(negedge clk);
        check(!valid_o && !done_o && !err_o, "R1", "after reset", valid_o + done_o + err_o, 0);

        issue(0, 0, 9);     idle(3);
        issue(1, 0, 7);     idle(3);
        issue(2, 0, 30);    idle(5);
        issue(3, 0, 21);    idle(9);
        issue(3, 1, 21);    idle(9);
        issue(2, 1, 11);    idle(5);
        issue(1, 1, 510);   idle(3);
        issue(0, 1, 3);     idle(3);
        issue(3, 0, 511);   idle(9);

        issue(7, 0, 505);   idle(12);
        pulse_term();       idle(3);
        issue(7, 1, 4);     idle(2);
        issue(4, 0, 1);     idle(2);
        issue(5, 1, 1);     idle(2);
        issue(6, 0, 1);     idle(2);

        focus = "R10";
        issue(3, 0, 40);    idle(2);
        issue(2, 1, 100);   idle(6);
        issue(7, 0, 200);   idle(3);
        @(negedge clk);
        cmd_i = 1; term_i = 1; bl_code_i = 3'd1; btype_i = 0; start_col_i = COL_W'(77);
        @(negedge clk);
        cmd_i = 0; term_i = 0;
        idle(4);
        issue(3, 0, 8);     idle(2);
        issue(5, 0, 0);     idle(4);
        focus = "R8";
        issue(3, 1, 50);    idle(2);
        pulse_term();       idle(3);
        pulse_term();       idle(2);
        focus = "";

        for (int n = 0; n < 300; n++) begin
            int c;
            c = $urandom_range(0, 7);
            issue(c, 1'($urandom_range(0, 1)), int'($urandom_range(0, NCOL - 1)));
            for (int g = 0; g < int'($urandom_range(0, 12)); g++) begin
                @(negedge clk);
                term_i = ($urandom_range(0, 15) == 0);
            end
            @(negedge clk);
            term_i = 0;
        end
        idle(12);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule